// File: doc/BRIEF.md
# Double-Word Boundary Transfer Splitter

This block takes a request to move a contiguous run of bytes, given as a start byte address and a length in bytes. It turns the request into a series of single-beat bus pieces, and no piece spans an 8-byte double word. Each piece carries its byte address, its byte count and a lane enable with one bit for each byte of the double word. Each piece also carries a flag that says whether the piece is naturally aligned.

A request is taken on a valid/ready handshake and only while the block is idle. Pieces leave on a second valid/ready handshake, and a flag marks the final piece. A one-cycle `done` pulse closes every request. This includes a request of length zero, which produces no pieces. Steering of the data bytes and any bus timing beyond the handshakes are left to neighbouring logic.

Top module: `dword_splitter`

## Requirements
- R1: While reset is held and in the first cycle after its synchronous release, `out_valid` and `done` are 0 and `req_ready` is 1.
- R2: The first piece of a request has `out_addr` equal to the start address. Its `out_count` is the smaller of the request length and the number of bytes from the start address up to the next 8-byte boundary (8 minus address bits [2:0]).
- R3: No piece crosses an 8-byte boundary: address bits [2:0] plus `out_count` never exceeds 8. Every piece after the first starts on a boundary, each piece begins at the byte after the end of the previous one, and the counts add up to the request length.
- R4: `out_lanes` bit i is 1 exactly when offset <= i <= offset + `out_count` - 1, where offset is `out_addr` bits [2:0], so the number of set lanes equals `out_count`.
- R5: `out_aligned` is 1 exactly when `out_count` is 1, 2, 4 or 8 and `out_addr` is a multiple of `out_count`; a 1-byte piece is therefore always aligned.
- R6: `out_last` is 1 on the final piece of a request and 0 on every other piece.
- R7: `done` is 1 for exactly one cycle, the cycle after the final piece's handshake, and is 0 while pieces of the request are pending.
- R8: A request of length 0 produces no piece (`out_valid` stays 0) and raises `done` in the cycle after it is accepted.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and all piece fields hold their values into the next cycle.
- R10: `req_ready` is 0 while pieces are pending, and a request presented in that time has no effect on the pieces issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Start byte address of the run |
| req_len | input | LEN_W | Length of the run in bytes |
| out_valid | output | 1 | Piece present |
| out_ready | input | 1 | Downstream takes the piece |
| out_addr | output | ADDR_W | Byte address of the piece |
| out_count | output | $clog2(DW_BYTES)+1 | Bytes in the piece, 1 to DW_BYTES |
| out_lanes | output | DW_BYTES | Byte-lane enable within the double word |
| out_aligned | output | 1 | Piece is naturally aligned |
| out_last | output | 1 | Final piece of the request |
| done | output | 1 | One-cycle pulse when a request completes |

## Verification
The assertions check the per-cycle properties of any piece on every cycle. These are the boundary limit, lane population matching the count, single-byte pieces being aligned, pieces holding still under backpressure, and the exclusion between taking a request and issuing pieces. They also check that a piece following a non-final handshake starts on a boundary. Only the bench's sweeps show the exact arithmetic of each piece, with a separate check per field. The sweeps cover every start offset across two double words and every length up to 20 bytes, both with `out_ready` held high and with one stall per piece. They also show the exact cycle of `done` for zero and non-zero lengths, and that requests presented while busy are ignored.

// File: rtl/dws_pkg.sv
package dws_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EMIT = 1'b1
  } dws_state_e;

endpackage

// File: rtl/dws_rst_sync.sv
module dws_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;

endmodule

// File: rtl/dws_piece_calc.sv
module dws_piece_calc #(
  parameter int LEN_W    = 12,
  parameter int DW_BYTES = 8,
  localparam int OFF_W   = $clog2(DW_BYTES),
  localparam int CNT_W   = OFF_W + 1
) (
  input  logic [OFF_W-1:0]    offset,
  input  logic [LEN_W-1:0]    remain,
  output logic [CNT_W-1:0]    count,
  output logic [DW_BYTES-1:0] lanes,
  output logic                aligned
);

  localparam logic [CNT_W-1:0] DW_CNT = CNT_W'(DW_BYTES);

  logic [CNT_W-1:0] room;
  logic [CNT_W:0]   span_end;
  logic [CNT_W-1:0] off_ext;
  logic             pow2;

  always_comb begin
    off_ext = {1'b0, offset};
    room    = DW_CNT - off_ext;
    if (remain < LEN_W'(room)) begin
      count = remain[CNT_W-1:0];
    end else begin
      count = room;
    end
    span_end = {1'b0, off_ext} + {1'b0, count};
  end

  for (genvar i = 0; i < DW_BYTES; i++) begin : g_lane
    localparam logic [CNT_W:0] IDX = (CNT_W+1)'(i);
    assign lanes[i] = (IDX >= {2'b00, offset}) && (IDX < span_end);
  end

  always_comb begin
    pow2    = (count != '0) && ((count & (count - 1'b1)) == '0);
    aligned = pow2 && ((off_ext & (count - 1'b1)) == '0);
  end

endmodule

// File: rtl/dws_seq.sv
module dws_seq
  import dws_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 12,
  parameter int DW_BYTES = 8,
  localparam int OFF_W   = $clog2(DW_BYTES),
  localparam int CNT_W   = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n_sync,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_ready,
  output logic              out_valid,
  input  logic              out_ready,
  input  logic [CNT_W-1:0]  piece_count,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LEN_W-1:0]  cur_remain,
  output logic              piece_last,
  output logic              done
);

  dws_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic              done_q, done_d;
  logic              ptr_en;
  logic              accept;
  logic              fire;
  logic              last;

  always_comb begin
    req_ready = (state_q == ST_IDLE);
    out_valid = (state_q == ST_EMIT);
    accept    = req_valid && req_ready;
    fire      = out_valid && out_ready;
    last      = (rem_q == LEN_W'(piece_count));
  end

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    done_d  = 1'b0;
    ptr_en  = 1'b0;
    if (accept) begin
      if (req_len == '0) begin
        done_d = 1'b1;
      end else begin
        state_d = ST_EMIT;
        addr_d  = req_addr;
        rem_d   = req_len;
        ptr_en  = 1'b1;
      end
    end else if (fire) begin
      addr_d = addr_q + ADDR_W'(piece_count);
      rem_d  = rem_q - LEN_W'(piece_count);
      ptr_en = 1'b1;
      if (last) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (ptr_en) begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
    end
  end

  assign cur_addr   = addr_q;
  assign cur_remain = rem_q;
  assign piece_last = last;
  assign done       = done_q;

endmodule

// File: rtl/dword_splitter.sv
module dword_splitter #(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 12,
  parameter int DW_BYTES = 8,
  localparam int OFF_W   = $clog2(DW_BYTES),
  localparam int CNT_W   = OFF_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [LEN_W-1:0]    req_len,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [ADDR_W-1:0]   out_addr,
  output logic [CNT_W-1:0]    out_count,
  output logic [DW_BYTES-1:0] out_lanes,
  output logic                out_aligned,
  output logic                out_last,
  output logic                done
);

  logic              rst_n_sync;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  cur_remain;
  logic [CNT_W-1:0]  piece_count;

  dws_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  dws_piece_calc #(
    .LEN_W    (LEN_W),
    .DW_BYTES (DW_BYTES)
  ) u_calc (
    .offset  (cur_addr[OFF_W-1:0]),
    .remain  (cur_remain),
    .count   (piece_count),
    .lanes   (out_lanes),
    .aligned (out_aligned)
  );

  dws_seq #(
    .ADDR_W   (ADDR_W),
    .LEN_W    (LEN_W),
    .DW_BYTES (DW_BYTES)
  ) u_seq (
    .clk         (clk),
    .rst_n_sync  (rst_n_sync),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_len     (req_len),
    .req_ready   (req_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .piece_count (piece_count),
    .cur_addr    (cur_addr),
    .cur_remain  (cur_remain),
    .piece_last  (out_last),
    .done        (done)
  );

  assign out_addr  = cur_addr;
  assign out_count = piece_count;

endmodule

// File: rtl/dws_checker.sv
module dws_checker #(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 12,
  parameter int DW_BYTES = 8,
  localparam int OFF_W   = $clog2(DW_BYTES),
  localparam int CNT_W   = OFF_W + 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [ADDR_W-1:0]   out_addr,
  input logic [CNT_W-1:0]    out_count,
  input logic [DW_BYTES-1:0] out_lanes,
  input logic                out_aligned,
  input logic                out_last
);

  logic [CNT_W:0] span_end;
  assign span_end = {2'b00, out_addr[OFF_W-1:0]} + {1'b0, out_count};

  assert_no_cross_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_count != '0) && (span_end <= (CNT_W+1)'(DW_BYTES)));

  assert_next_on_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> out_valid && (out_addr[OFF_W-1:0] == '0));

  assert_lane_population_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_lanes) == int'(out_count)));

  assert_single_byte_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_count == CNT_W'(1)) |-> out_aligned);

  assert_hold_under_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_addr) && $stable(out_count)
      && $stable(out_lanes) && $stable(out_aligned) && $stable(out_last));

  assert_busy_blocks_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && req_ready));

  assert_req_not_lost_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |-> out_valid);

endmodule

bind dword_splitter dws_checker #(
  .ADDR_W   (ADDR_W),
  .LEN_W    (LEN_W),
  .DW_BYTES (DW_BYTES)
) u_dws_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_addr    (out_addr),
  .out_count   (out_count),
  .out_lanes   (out_lanes),
  .out_aligned (out_aligned),
  .out_last    (out_last)
);

// File: tb/dword_splitter_tb_top.sv
`timescale 1ns/1ps
module dword_splitter_tb_top;

  localparam int ADDR_W = 32;
  localparam int LEN_W  = 12;
  localparam int DWB    = 8;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr;
  logic [LEN_W-1:0]  req_len;
  logic              out_valid;
  logic              out_ready;
  logic [ADDR_W-1:0] out_addr;
  logic [3:0]        out_count;
  logic [DWB-1:0]    out_lanes;
  logic              out_aligned;
  logic              out_last;
  logic              done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  dword_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DW_BYTES(DWB)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_count(out_count),
    .out_lanes(out_lanes), .out_aligned(out_aligned),
    .out_last(out_last), .done(done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input longint act, input longint exp);
    chk(act == exp, tag, act, exp);
  endtask

  // Compare the presented piece with the expected one (R2..R6, R10)
  task automatic chk_piece(input longint ea, input int cnt, input int lanes,
                           input bit al, input bit lst, input bit first);
    chk_eq("R10 out_valid during piece", longint'(out_valid), 1);
    chk_eq("R10 req_ready low while busy", longint'(req_ready), 0);
    chk_eq(first ? "R2 first piece address" : "R3 piece address", longint'(out_addr), ea);
    chk_eq(first ? "R2 first piece count" : "R3 piece count", longint'(out_count), cnt);
    chk_eq("R4 lane enable", longint'(out_lanes), lanes);
    chk_eq("R5 aligned flag", longint'(out_aligned), longint'(al));
    chk_eq("R6 last flag", longint'(out_last), longint'(lst));
    chk_eq("R7 no done while pending", longint'(done), 0);
  endtask

  task automatic run_req(input longint addr, input int len, input bit stall);
    longint ea;
    int rem;
    bit first;
    @(negedge clk);
    chk_eq("R10 req_ready idle", longint'(req_ready), 1);
    req_valid = 1'b1;
    req_addr  = ADDR_W'(addr);
    req_len   = LEN_W'(len);
    out_ready = 1'b0;
    @(negedge clk);
    // request taken; keep presenting a bogus request while busy (R10)
    req_addr = ~ADDR_W'(addr);
    req_len  = LEN_W'(5);
    if (len == 0) begin
      req_valid = 1'b0;
      chk_eq("R8 done after zero length", longint'(done), 1);
      chk_eq("R8 no piece for zero length", longint'(out_valid), 0);
    end else begin
      ea = addr;
      rem = len;
      first = 1'b1;
      while (rem > 0) begin
        int off = int'(ea % DWB);
        int cnt = (rem < DWB - off) ? rem : DWB - off;
        int lanes = (((1 << cnt) - 1) << off) & 'hff;
        bit al = ((cnt == 1) || (cnt == 2) || (cnt == 4) || (cnt == 8)) && ((ea % cnt) == 0);
        bit lst = (rem == cnt);
        chk_piece(ea, cnt, lanes, al, lst, first);
        if (stall) begin
          out_ready = 1'b0;
          @(negedge clk);
          chk_piece(ea, cnt, lanes, al, lst, first); // held under stall (R9)
          chk_eq("R9 held piece address", longint'(out_addr), ea);
        end
        out_ready = 1'b1;
        if (lst) req_valid = 1'b0;
        @(negedge clk);
        out_ready = 1'b0;
        ea = ea + cnt;
        rem = rem - cnt;
        first = 1'b0;
      end
      chk_eq("R7 done after final piece", longint'(done), 1);
      chk_eq("R3 no piece beyond length", longint'(out_valid), 0);
    end
    chk_eq("R10 idle after request", longint'(req_ready), 1);
    @(negedge clk);
    chk_eq("R7 done lasts one cycle", longint'(done), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    req_len = '0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk_eq("R1 reset out_valid", longint'(out_valid), 0);
    chk_eq("R1 reset done", longint'(done), 0);
    chk_eq("R1 reset req_ready", longint'(req_ready), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_eq("R1 after release out_valid", longint'(out_valid), 0);
    chk_eq("R1 after release req_ready", longint'(req_ready), 1);
    for (int s = 0; s < 2; s++) begin
      for (int off = 0; off < 16; off++) begin
        for (int len = 0; len <= 20; len++) begin
          run_req(longint'('h0000_3a40 + off), len, s[0]);
        end
      end
    end
    // back-to-back zero-length requests (R8)
    run_req(longint'('h7), 0, 1'b0);
    run_req(longint'('hfff8), 0, 1'b0);
    // long run from an odd offset (R3)
    run_req(longint'('h1233), 100, 1'b0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule